// File: doc/BRIEF.md
# Deferred-Fault Poison Tag Tracker

This block keeps a single poison tag beside every architectural register so that a terminating exception raised by a speculatively scheduled instruction does not trap at once. It sits between decode and writeback. Each cycle at most one instruction is presented with its two source indices, its destination index, a speculative flag, a store flag and its exception indications. The block raises a fault only when a non-speculative consumer, or any store, meets a poisoned source or a terminating exception of its own. Resumable exceptions are passed straight through for immediate handling.

A speculative instruction that hits a terminating exception, or that reads a poisoned source, does not fault. It marks its destination as poisoned instead, so the deferred fault follows the data. A normal instruction that completes cleanly clears the tag of the register it writes. For context switches, the whole tag vector is visible on an output and can be cleared in one cycle. It can later be reloaded from a supplied word.

Register 0 is hard-wired clean. Source index 0 therefore means "no source".

Top module: `poison_tracker`

## Requirements
- R1: Reset clears every poison tag, and the tag of register 0 reads 0 at all times, whatever is written or reloaded.
- R2: A speculative non-store instruction with a terminating exception and a destination write sets the destination tag at the next clock edge and does not assert `fault_o`.
- R3: A speculative non-store instruction that writes a destination sets that tag to the OR of its two source tags and its terminating-exception flag, and never asserts `fault_o`.
- R4: A normal instruction that reads a poisoned source asserts `fault_o` in the same cycle, and its destination tag keeps its old value.
- R5: A normal instruction with a terminating exception asserts `fault_o` in the same cycle.
- R6: `resume_o` is high in exactly the cycles where a valid instruction carries a resumable exception, whether it is speculative or not. Such an exception changes no tag.
- R7: A store (`store_i`=1) is handled as normal even when `spec_i`=1. It faults if the address source (`src_a_i`) or the data source (`src_b_i`) is poisoned, and it writes no tag.
- R8: A normal non-store instruction that writes a destination without faulting clears that destination's tag.
- R9: `poison_o` shows the tag vector at all times, bit n being register n. When `save_clr_i` is high, the vector shown in that cycle is the saved state, and all tags are 0 after the edge. Any writeback update in that cycle is dropped.
- R10: When `restore_i` is high, the tags take `restore_vec_i` (bit 0 forced to 0) at the edge. This has priority over both save and writeback.
- R11: `fault_o` and `resume_o` are combinational from the current tags and inputs. They are low when `wb_valid_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_valid_i | input | 1 | An instruction is presented this cycle |
| src_a_i | input | IW | First source index (store address) |
| src_b_i | input | IW | Second source index (store data) |
| dst_i | input | IW | Destination index |
| dst_we_i | input | 1 | Instruction writes its destination |
| spec_i | input | 1 | Instruction is speculative |
| store_i | input | 1 | Instruction is a store |
| exc_term_i | input | 1 | Instruction raised a terminating exception |
| exc_resume_i | input | 1 | Instruction raised a resumable exception |
| save_clr_i | input | 1 | Save-and-clear all tags |
| restore_i | input | 1 | Reload all tags |
| restore_vec_i | input | NREGS | Tag word to reload |
| fault_o | output | 1 | Deferred or immediate terminating fault |
| resume_o | output | 1 | Resumable exception passed through |
| poison_o | output | NREGS | Current tag vector |

## Verification
The assertions take for granted that every input is a known value once reset is released. Their tag-update checks also assume that neither save nor restore is raised in the cycle they examine, and they are guarded on exactly that. Register indices always fit the register count, because NREGS is a power of two. The stimulus draws indices from a small window so that producers and consumers collide often. It raises save or restore only rarely, and it includes directed cases where save, restore and a writeback arrive in the same cycle to exercise the priority order.

// File: rtl/poison_tracker.sv
module poison_tracker #(
  parameter int NREGS = 32,
  localparam int IW = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wb_valid_i,
  input  logic [IW-1:0]    src_a_i,
  input  logic [IW-1:0]    src_b_i,
  input  logic [IW-1:0]    dst_i,
  input  logic             dst_we_i,
  input  logic             spec_i,
  input  logic             store_i,
  input  logic             exc_term_i,
  input  logic             exc_resume_i,
  input  logic             save_clr_i,
  input  logic             restore_i,
  input  logic [NREGS-1:0] restore_vec_i,
  output logic             fault_o,
  output logic             resume_o,
  output logic [NREGS-1:0] poison_o
);

  logic [NREGS-1:0] tag_q;
  logic src_hit, as_normal, upd, nxt_bit;

  assign src_hit   = tag_q[src_a_i] | tag_q[src_b_i];
  assign as_normal = ~spec_i | store_i;
  assign fault_o   = wb_valid_i & as_normal & (src_hit | exc_term_i);
  assign resume_o  = wb_valid_i & exc_resume_i;
  assign upd       = wb_valid_i & dst_we_i & ~store_i & (dst_i != '0) & (spec_i | ~fault_o);
  assign nxt_bit   = ~as_normal & (src_hit | exc_term_i);
  assign poison_o  = tag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          tag_q <= '0;
    else if (restore_i)  tag_q <= {restore_vec_i[NREGS-1:1], 1'b0};
    else if (save_clr_i) tag_q <= '0;
    else if (upd)        tag_q[dst_i] <= nxt_bit;
  end

  AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    !tag_q[0]); // R1
  AST_SPEC_TERM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid_i && spec_i && !store_i && exc_term_i && dst_we_i && dst_i != '0 && !save_clr_i && !restore_i
    |=> tag_q[$past(dst_i)]); // R2
  AST_SPEC_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid_i && spec_i && !store_i |-> !fault_o); // R3
  AST_NORMAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid_i && !spec_i && !store_i && fault_o && !save_clr_i && !restore_i
    |=> $stable(tag_q)); // R4
  AST_STORE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid_i && store_i && !save_clr_i && !restore_i |=> $stable(tag_q)); // R7
  AST_NORMAL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid_i && !spec_i && !store_i && dst_we_i && !fault_o && !save_clr_i && !restore_i
    |=> !tag_q[$past(dst_i)]); // R8
  AST_SAVE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    save_clr_i && !restore_i |=> tag_q == '0); // R9
  AST_RESTORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    restore_i |=> tag_q[NREGS-1:1] == $past(restore_vec_i[NREGS-1:1])); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_valid_i |-> !fault_o && !resume_o); // R11

endmodule

// File: tb/test_poison_tracker.sv
module test_poison_tracker;
  localparam int N = 32;
  localparam int IW = $clog2(N);

  logic clk = 0, rst_n = 0;
  logic wb_valid, dst_we, spec, store, term, resm, save, rest;
  logic [IW-1:0] sa, sb, dst;
  logic [N-1:0] rvec;
  logic fault, resume;
  logic [N-1:0] poison;

  int checks = 0, errors = 0;
  bit ref_tag [N];
  bit finished = 0;

  always #4 clk = ~clk;

  poison_tracker #(.NREGS(N)) i_poison_tracker (
    .clk(clk), .rst_n(rst_n), .wb_valid_i(wb_valid), .src_a_i(sa), .src_b_i(sb),
    .dst_i(dst), .dst_we_i(dst_we), .spec_i(spec), .store_i(store),
    .exc_term_i(term), .exc_resume_i(resm), .save_clr_i(save), .restore_i(rest),
    .restore_vec_i(rvec), .fault_o(fault), .resume_o(resume), .poison_o(poison));

  function automatic logic [N-1:0] ref_vec();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = ref_tag[i];
    return v;
  endfunction

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wb_valid = 0; dst_we = 0; spec = 0; store = 0; term = 0; resm = 0;
    save = 0; rest = 0; sa = 0; sb = 0; dst = 0; rvec = '0;
  endtask

  // drive at negedge, check combinational outputs, advance model, step one clock
  task automatic op(string req, bit v, int a, int b, int d, bit we, bit sp, bit st,
                    bit tm, bit rs, bit sv, bit rt, logic [N-1:0] rv);
    bit hit, ef;
    wb_valid = v; sa = IW'(a); sb = IW'(b); dst = IW'(d); dst_we = we; spec = sp;
    store = st; term = tm; resm = rs; save = sv; rest = rt; rvec = rv;
    #2;
    hit = ref_tag[a] | ref_tag[b];
    ef = v && (!sp || st) && (hit || tm);
    chk({req, " fault"}, N'(fault), N'(ef));
    chk({req, " resume R6"}, N'(resume), N'(v && rs));
    chk({req, " vec"}, poison, ref_vec());
    if (rt) begin
      for (int i = 0; i < N; i++) ref_tag[i] = rv[i];
      ref_tag[0] = 0;
    end else if (sv) begin
      for (int i = 0; i < N; i++) ref_tag[i] = 0;
    end else if (v && we && !st && d != 0) begin
      if (sp) ref_tag[d] = hit || tm;
      else if (!ef) ref_tag[d] = 0;
    end
    @(negedge clk);
    chk({req, " after"}, poison, ref_vec());
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle();
    for (int i = 0; i < N; i++) ref_tag[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 reset state", poison, '0);
    // R2: speculative load with terminating exception poisons r5, no fault
    op("R2 spec term", 1, 1, 0, 5, 1, 1, 0, 1, 0, 0, 0, '0);
    chk("R2 r5 poisoned", N'(poison[5]), N'(1));
    // R3: spec consumer propagates poison r5 -> r6
    op("R3 spec prop", 1, 5, 2, 6, 1, 1, 0, 0, 0, 0, 0, '0);
    chk("R3 r6 poisoned", N'(poison[6]), N'(1));
    // R3: clean spec write clears r6
    op("R3 spec clean", 1, 2, 3, 6, 1, 1, 0, 0, 0, 0, 0, '0);
    chk("R3 r6 clean", N'(poison[6]), N'(0));
    // R4: normal read of poisoned r5 faults, r7 unchanged
    op("R4 normal fault", 1, 0, 5, 7, 1, 0, 0, 0, 0, 0, 0, '0);
    // R5: normal terminating exception
    op("R5 normal term", 1, 1, 2, 8, 1, 0, 0, 1, 0, 0, 0, '0);
    // R6: resumable exception on speculative and normal instructions
    op("R6 spec resume", 1, 1, 2, 9, 0, 1, 0, 0, 1, 0, 0, '0);
    op("R6 norm resume", 1, 1, 2, 9, 0, 0, 0, 0, 1, 0, 0, '0);
    // R7: speculative store with poisoned data, and with poisoned address
    op("R7 store data", 1, 1, 5, 5, 1, 1, 1, 0, 0, 0, 0, '0);
    op("R7 store addr", 1, 5, 1, 5, 1, 0, 1, 0, 0, 0, 0, '0);
    chk("R7 r5 still set", N'(poison[5]), N'(1));
    // R8: normal clean write clears r5
    op("R8 normal clear", 1, 1, 2, 5, 1, 0, 0, 0, 0, 0, 0, '0);
    chk("R8 r5 clean", N'(poison[5]), N'(0));
    // R1: writes to r0 never poison it
    op("R1 r0 write", 1, 0, 0, 0, 1, 1, 0, 1, 0, 0, 0, '0);
    // R10: restore with bit0 set, then R9 save with a colliding writeback
    op("R10 restore", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'hA5A5_0F0F);
    chk("R10 r0 forced", N'(poison[0]), N'(0));
    op("R9 save drop wb", 1, 0, 0, 4, 1, 1, 0, 1, 0, 1, 0, '0);
    chk("R9 cleared", poison, '0);
    op("R10 over save", 1, 0, 0, 4, 1, 1, 0, 1, 0, 1, 1, 32'h0000_8002);
    chk("R10 priority", poison, 32'h0000_8002);
    op("R11 idle", 0, 1, 15, 3, 1, 0, 0, 1, 1, 0, 0, '0);
    // mixed random traffic against the reference model
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom;
      op("R3 R4 R7 R8 mix", r[0] | r[1], $urandom % 8, $urandom % 8, $urandom % 8,
         r[2], r[3], (r[6:4] == 0), (r[9:7] == 0), (r[12:10] == 0),
         (r[19:13] == 0), (r[26:20] == 0), N'($urandom));
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule